// File: doc/BRIEF.md
# Banked Clock Fanout with Per-Bank Divide and Glitch-Free Enable

This block distributes one reference clock to sixteen outputs arranged as four banks of four. A select input chooses which of two incoming reference clocks is distributed. Each bank has its own mode input and its own enable input. The mode input picks either the full-rate clock or the clock divided by two. The enable input stops a bank cleanly, leaving its outputs low, and restarts it later.

Enable inputs may change at any time relative to the reference. Each one passes through a short synchronizer that is clocked on the falling edge of the selected clock. A new enable value therefore only reaches a bank while the clock is low, so a bank never emits a shortened high pulse. A single active-low input does two jobs. While it is low, every output is released to high impedance, and the divide-by-two flops are cleared at each rising edge of the selected clock.

Top module: `clkfan_banked`

## Requirements
- R1: The block has sixteen outputs. Output index i belongs to bank i/4, and all four outputs of a bank always carry the same waveform.
- R2: With `ref_sel` = 0 the banks are driven from `ref_clk_a`. With `ref_sel` = 1 they are driven from `ref_clk_b`.
- R3: A bank whose `bank_div` bit is 0 runs in pass mode. While enabled, it is high exactly while the selected clock is high, giving one rising edge per clock period.
- R4: A bank whose `bank_div` bit is 1 runs in divide mode. While enabled, it produces one rising edge per two clock periods, and each high phase lasts one full clock period.
- R5: A bank whose `bank_en` bit is 0 settles low within four clock periods and stays low. The other banks keep running unaffected.
- R6: No high pulse on any bank is ever shorter than half a clock period in pass mode, or one full clock period in divide mode, whenever the enables toggle. A bank only takes up a new enable value while the selected clock is low.
- R7: While `rst_oe_n` is 0, all sixteen outputs are high impedance.
- R8: When `rst_oe_n` is 0 at a rising clock edge, the divide flops are cleared. After release, a steadily enabled divide-mode bank reads low and goes high on the first rising edge of the selected clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_a | input | 1 | Reference clock chosen when ref_sel is 0 |
| ref_clk_b | input | 1 | Reference clock chosen when ref_sel is 1 |
| ref_sel | input | 1 | Reference select |
| bank_div | input | 4 | Per-bank mode: 0 pass, 1 divide by two |
| bank_en | input | 4 | Per-bank asynchronous enable, 1 runs the bank |
| rst_oe_n | input | 1 | Active-low divider clear and output release |
| clk_out | output | 16 | Fanned-out clocks, bank b on bits 4b+3..4b |

## Verification
The bench builds the block with its default parameters: four banks of four outputs and a two-stage enable synchronizer. Because the synchronizer is short, an enable toggle takes effect within a few clock periods. This lets dozens of asynchronous toggles fit in a short run, and each one is followed by measurement of every resulting high pulse. Four banks are enough to hold pass and divide modes side by side, to stop one bank while its neighbours keep running, and to count edges on both reference clocks. The bench places a pull-up on each output net, so the high-impedance state reads as a steady 1 that a driven bank could not produce.

// File: rtl/clkfan_pkg.sv
`timescale 1ns/1ps
// Package: clkfan_pkg
// Shared encodings for the banked clock fanout.
// Assumes: one bit per bank selects the divide mode.
package clkfan_pkg;

    // Per-bank rate encoding carried on bank_div.
    typedef enum logic {
        RATE_PASS = 1'b0,
        RATE_HALF = 1'b1
    } bank_rate_e;

    // Default geometry used by the top level.
    localparam int unsigned DEF_BANKS       = 4;
    localparam int unsigned DEF_OUTS_PER_BK = 4;
    localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/clkfan_ref_mux.sv
`timescale 1ns/1ps
// Module: clkfan_ref_mux
// Picks one of two reference clocks.
// Assumes: ref_sel changes only while the outputs are in reset or all
// banks are disabled, because a switch can create one irregular cycle.
module clkfan_ref_mux (
    input  logic ref_clk_a,
    input  logic ref_clk_b,
    input  logic ref_sel,
    output logic src_clk
);

    // Purpose: route the chosen reference to the fanout tree.
    always_comb begin
        src_clk = ref_sel ? ref_clk_b : ref_clk_a;
    end

endmodule

// File: rtl/clkfan_en_sync.sv
`timescale 1ns/1ps
// Module: clkfan_en_sync
// Carries one asynchronous bank enable into the clock domain of the
// selected reference. Every stage captures on the falling edge, so the
// synchronized value can only change while the clock is low.
// Assumes: STAGES >= 1. The chain has no reset on purpose. It only
// follows the enable input, and the reset input is defined to clear
// just the dividers and the drive.
module clkfan_en_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic src_clk,
    input  logic en_async,
    output logic en_q
);

    logic [STAGES-1:0] chain;

    // Purpose: shift the enable through the falling-edge stages.
    always_ff @(negedge src_clk) begin
        chain[0] <= en_async;
        for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
        end
    end

    // Purpose: present the last stage to the bank.
    always_comb begin
        en_q = chain[STAGES-1];
    end

endmodule

// File: rtl/clkfan_bank.sv
`timescale 1ns/1ps
// Module: clkfan_bank
// Produces one bank's clock from the selected reference.
// Pass mode gates the clock with the synchronized enable. Divide mode
// toggles a flop on each rising edge. When the enable drops, the flop
// finishes its high phase and parks low, so every divided pulse is one
// full clock period wide.
// Assumes: en_q only changes while src_clk is low. rst_n is sampled
// synchronously (active low).
module clkfan_bank
    import clkfan_pkg::*;
(
    input  logic src_clk,
    input  logic rst_n,
    input  logic en_q,
    input  logic rate_sel,
    output logic bank_q,
    output logic div_ff
);

    bank_rate_e rate;

    // Purpose: decode the rate bit into the shared encoding.
    always_comb begin
        rate = bank_rate_e'(rate_sel);
    end

    // Purpose: divide-by-two flop, cleared by reset and parked when idle.
    always_ff @(posedge src_clk) begin
        if (!rst_n) begin
            div_ff <= 1'b0;
        end else if (en_q && (rate == RATE_HALF)) begin
            div_ff <= ~div_ff;
        end else begin
            div_ff <= 1'b0;
        end
    end

    // Purpose: choose the gated full-rate clock or the divided clock.
    always_comb begin
        if (rate == RATE_HALF) begin
            bank_q = div_ff;
        end else begin
            bank_q = src_clk & en_q;
        end
    end

endmodule

// File: rtl/clkfan_banked.sv
`timescale 1ns/1ps
// Module: clkfan_banked (top)
// Fans one of two reference clocks out to BANKS banks of OUTS_PER_BK
// outputs. Each bank has its own rate select and synchronized enable.
// rst_oe_n low releases every output to high impedance and clears
// the dividers at the next rising edge of the selected clock.
// Assumes: bank_div changes only while its bank is disabled, and
// ref_sel changes only while the outputs are in reset.
module clkfan_banked
    import clkfan_pkg::*;
#(
    parameter int unsigned BANKS       = DEF_BANKS,
    parameter int unsigned OUTS_PER_BK = DEF_OUTS_PER_BK,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                           ref_clk_a,
    input  logic                           ref_clk_b,
    input  logic                           ref_sel,
    input  logic [BANKS-1:0]               bank_div,
    input  logic [BANKS-1:0]               bank_en,
    input  logic                           rst_oe_n,
    output logic [BANKS*OUTS_PER_BK-1:0]   clk_out
);

    localparam int unsigned NUM_OUTS = BANKS * OUTS_PER_BK;

    logic             src_clk;
    logic [BANKS-1:0] en_q;
    logic [BANKS-1:0] div_ff;
    logic [BANKS-1:0] bank_q;

    clkfan_ref_mux u_mux (
        .ref_clk_a (ref_clk_a),
        .ref_clk_b (ref_clk_b),
        .ref_sel   (ref_sel),
        .src_clk   (src_clk)
    );

    // One synchronizer and one clock generator per bank.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        clkfan_en_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .src_clk  (src_clk),
            .en_async (bank_en[b]),
            .en_q     (en_q[b])
        );

        clkfan_bank u_bank (
            .src_clk  (src_clk),
            .rst_n    (rst_oe_n),
            .en_q     (en_q[b]),
            .rate_sel (bank_div[b]),
            .bank_q   (bank_q[b]),
            .div_ff   (div_ff[b])
        );
    end

    // Output drivers: each bit follows its bank, floated during reset.
    for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
        assign clk_out[o] = rst_oe_n ? bank_q[o / OUTS_PER_BK] : 1'bz;
    end

endmodule

// File: rtl/clkfan_banked_chk.sv
`timescale 1ns/1ps
// Module: clkfan_banked_chk
// Temporal checks on the bank clocks, attached to the top by bind.
// Assumes: it sees the selected clock and the per-bank internal state.
module clkfan_banked_chk #(
    parameter int unsigned BANKS = 4
) (
    input logic             src_clk,
    input logic             rst_oe_n,
    input logic [BANKS-1:0] en_q,
    input logic [BANKS-1:0] rate_sel,
    input logic [BANKS-1:0] div_ff,
    input logic [BANKS-1:0] bank_q
);

    logic [BANKS-1:0] en_at_rise;

    // Purpose: remember the synchronized enables seen at each rising edge.
    always_ff @(posedge src_clk) begin
        en_at_rise <= en_q;
    end

    AST_EN_STEADY_HIGH_PHASE: assert property (@(negedge src_clk) disable iff (!rst_oe_n)
        en_q == en_at_rise); // R6

    AST_DIV_CLEARED: assert property (@(posedge src_clk)
        !rst_oe_n |=> (div_ff == '0)); // R8

    for (genvar b = 0; b < BANKS; b++) begin : g_chk
        AST_IDLE_BANK_LOW: assert property (@(negedge src_clk) disable iff (!rst_oe_n)
            (!en_q[b] && $past(!en_q[b])) |-> !bank_q[b]); // R5

        AST_HALF_TOGGLES: assert property (@(posedge src_clk) disable iff (!rst_oe_n)
            (en_q[b] && rate_sel[b]) |=> (div_ff[b] != $past(div_ff[b]))); // R4

        AST_PASS_HIGH: assert property (@(negedge src_clk) disable iff (!rst_oe_n)
            (en_q[b] && $past(en_q[b]) && !rate_sel[b]) |-> bank_q[b]); // R3
    end

endmodule

bind clkfan_banked clkfan_banked_chk #(.BANKS(BANKS)) u_chk (
    .src_clk  (src_clk),
    .rst_oe_n (rst_oe_n),
    .en_q     (en_q),
    .rate_sel (bank_div),
    .div_ff   (div_ff),
    .bank_q   (bank_q)
);

// File: tb/sim_clkfan_banked.sv
`timescale 1ns/1ps
// Directed bench for clkfan_banked: one task per scenario.
module sim_clkfan_banked;

    localparam int NB  = 4;
    localparam int OPB = 4;
    localparam int NO  = NB * OPB;

    logic          ref_a = 1'b0;
    logic          ref_b = 1'b0;
    logic          ref_sel;
    logic [NB-1:0] div;
    logic [NB-1:0] en;
    logic          rst_n;
    wire  [NO-1:0] q;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  counting = 0;
    bit  meas = 0;
    int  cnt [NB];
    real rise_t [NB];
    real min_hi [NB];
    bit  have [NB];

    always #10 ref_a = ~ref_a;   // 50 MHz
    always #16 ref_b = ~ref_b;   // 32 ns period

    clkfan_banked u0 (
        .ref_clk_a (ref_a),
        .ref_clk_b (ref_b),
        .ref_sel   (ref_sel),
        .bank_div  (div),
        .bank_en   (en),
        .rst_oe_n  (rst_n),
        .clk_out   (q)
    );

    // Pull-ups make a released output read as a steady 1.
    for (genvar g = 0; g < NO; g++) begin : g_pu
        pullup (q[g]);
    end

    // Edge counters and high-pulse width monitors on bit 0 of each bank.
    for (genvar g = 0; g < NB; g++) begin : g_mon
        always @(posedge q[g*OPB]) begin
            if (counting) cnt[g]++;
            if (meas) begin
                rise_t[g] = $realtime;
                have[g]   = 1'b1;
            end
        end
        always @(negedge q[g*OPB]) begin
            real w;
            if (meas && have[g]) begin
                w = $realtime - rise_t[g];
                if (w < min_hi[g]) min_hi[g] = w;
                have[g] = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [OPB-1:0] bank_bits(input int b);
        return q[b*OPB +: OPB];
    endfunction

    // Change rates only with all banks stopped, then restart them.
    task automatic set_rates(input logic [NB-1:0] r);
        en = '0;
        repeat (5) @(posedge ref_a);
        div = r;
        en = '1;
        repeat (6) @(posedge ref_a);
    endtask

    // R7: in reset every output floats (reads as pulled-up 1).
    task automatic t_reset_hiz();
        for (int k = 0; k < 4; k++) begin
            @(negedge ref_a); #5;
            chk(q === {NO{1'b1}}, "R7 float in reset (low phase)", q, {NO{1'b1}});
            @(posedge ref_a); #5;
            chk(q === {NO{1'b1}}, "R7 float in reset (high phase)", q, {NO{1'b1}});
        end
    endtask

    // R8: dividers start low after release and rise on the first edge.
    task automatic t_release();
        @(negedge ref_a); #5;
        rst_n = 1'b1;
        #1;
        chk(q === '0, "R8 divided outputs low after release", q, 0);
        @(posedge ref_a); #3;
        chk(q === {NO{1'b1}}, "R8 first rising edge drives high", q, {NO{1'b1}});
        @(posedge ref_a); #3;
        chk(q === '0, "R4 divided output low on second edge", q, 0);
    endtask

    // R1 and R3: bank bits identical, pass banks follow the clock.
    task automatic t_uniform();
        set_rates(4'b1010);
        for (int k = 0; k < 8; k++) begin
            @(posedge ref_a); #3;
            for (int b = 0; b < NB; b++)
                chk(bank_bits(b) == {OPB{bank_bits(b)[0]}}, "R1 bank bits equal",
                    bank_bits(b), {OPB{bank_bits(b)[0]}});
            chk(bank_bits(0) == '1 && bank_bits(2) == '1, "R3 pass banks high in high phase",
                {bank_bits(2), bank_bits(0)}, 8'hFF);
            @(negedge ref_a); #3;
            chk(bank_bits(0) == '0 && bank_bits(2) == '0, "R3 pass banks low in low phase",
                {bank_bits(2), bank_bits(0)}, 8'h00);
        end
    endtask

    // R2/R3/R4: count rising edges over 20 periods of the selected clock.
    task automatic t_rate(input bit use_b, input real per, input string tag);
        if (use_b) @(negedge ref_b); else @(negedge ref_a);
        #(per / 4.0);
        for (int b = 0; b < NB; b++) cnt[b] = 0;
        counting = 1'b1;
        #(20.0 * per);
        counting = 1'b0;
        chk(cnt[0] == 20, {tag, " R3 pass bank0 edges"}, cnt[0], 20);
        chk(cnt[2] == 20, {tag, " R3 pass bank2 edges"}, cnt[2], 20);
        chk(cnt[1] == 10, {tag, " R4 half bank1 edges"}, cnt[1], 10);
        chk(cnt[3] == 10, {tag, " R4 half bank3 edges"}, cnt[3], 10);
    endtask

    // R5: one bank stopped holds low, the others keep running.
    task automatic t_disable();
        en = 4'b1011;
        repeat (5) @(posedge ref_a);
        #3;
        for (int b = 0; b < NB; b++) cnt[b] = 0;
        counting = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(posedge ref_a); #3;
            chk(bank_bits(2) == '0, "R5 stopped bank low (high phase)", bank_bits(2), 0);
            @(negedge ref_a); #3;
            chk(bank_bits(2) == '0, "R5 stopped bank low (low phase)", bank_bits(2), 0);
        end
        counting = 1'b0;
        chk(cnt[0] == 10, "R5 neighbour bank0 keeps running", cnt[0], 10);
        chk(cnt[3] == 5, "R5 neighbour bank3 keeps running", cnt[3], 5);
        en = '1;
        repeat (6) @(posedge ref_a);
    endtask

    // R6: asynchronous enable toggling never yields a short high pulse.
    task automatic t_glitch();
        for (int b = 0; b < NB; b++) begin
            min_hi[b] = 1.0e9;
            have[b]   = 1'b0;
        end
        meas = 1'b1;
        for (int k = 0; k < 64; k++) begin
            #(7 + (k * 13) % 23);
            en[k % NB] = ~en[k % NB];
        end
        en = '1;
        repeat (8) @(posedge ref_a);
        meas = 1'b0;
        chk(min_hi[0] > 9.99, "R6 pass bank0 min high (ps)", $rtoi(min_hi[0] * 1000), 10000);
        chk(min_hi[2] > 9.99, "R6 pass bank2 min high (ps)", $rtoi(min_hi[2] * 1000), 10000);
        chk(min_hi[1] > 19.99, "R6 half bank1 min high (ps)", $rtoi(min_hi[1] * 1000), 20000);
        chk(min_hi[3] > 19.99, "R6 half bank3 min high (ps)", $rtoi(min_hi[3] * 1000), 20000);
    endtask

    // R2: switch to the second reference under reset, then measure rate.
    task automatic t_sel_b();
        @(negedge ref_a); #2;
        rst_n = 1'b0;
        #3;
        chk(q === {NO{1'b1}}, "R7 float after reset re-asserted", q, {NO{1'b1}});
        ref_sel = 1'b1;
        repeat (4) @(posedge ref_b);
        @(negedge ref_b); #4;
        rst_n = 1'b1;
        repeat (4) @(posedge ref_b);
        t_rate(1'b1, 32.0, "R2 ref_b");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        ref_sel = 1'b0;
        rst_n   = 1'b0;
        en      = '1;
        div     = '1;
        repeat (6) @(posedge ref_a);
        t_reset_hiz();
        t_release();
        t_uniform();
        t_rate(1'b0, 20.0, "R2 ref_a");
        t_disable();
        t_glitch();
        t_sel_b();
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

endmodule